// File: doc/BRIEF.md
# SIMT Branch Divergence Mask Unit

This unit tracks the program counter and the per-thread active mask of one 32-thread warp as it runs through conditional branches. Every issued instruction is reported to it with an `advance` strobe. For a branch, each thread also supplies its own condition bit, together with the taken target, the fall-through address and the reconvergence address where the two paths meet again. Condition bits of threads that are currently inactive are ignored.

If all active threads agree, the unit redirects the warp to the chosen path and leaves the mask alone. If they disagree, the unit runs the taken threads first. It saves the not-taken threads and their start address on a small reconvergence stack. When the program counter reaches the saved reconvergence address, the unit spends one cycle switching to the waiting path with its own mask. At the second arrival it spends one cycle popping the entry and restoring the union of both paths' masks. Divergences can nest to the depth of the stack. A divergence that finds the stack full sets a sticky error flag.

The `issueValid` output is low during the switching and popping cycles, and the instruction sequencer should not issue then. A launch starts a fresh warp at a given address with every thread active.

Top module: `simt_diverge_unit`

## Requirements
- R1: After reset, `pc` is 0, `activeMask` is all ones, `stackErr` is 0 and `issueValid` is 1.
- R2: `launch` sets `pc` to `launchPc`, sets `activeMask` to all ones, empties the stack and clears `stackErr` on the next edge. It takes priority over an `advance` in the same cycle.
- R3: An accepted `advance` with `isBranch`=0 adds 4 to `pc` and keeps `activeMask`.
- R4: An accepted branch whose condition bit is 1 for every active thread moves `pc` to `takenPc`, keeps the mask and pushes nothing.
- R5: An accepted branch whose condition bit is 0 for every active thread moves `pc` to `fallPc`, keeps the mask and pushes nothing.
- R6: Condition bits of inactive threads have no effect on whether a branch is uniform or divergent.
- R7: An accepted divergent branch moves `pc` to `takenPc`, sets `activeMask` to condition AND mask, and pushes {`reconvPc`, `fallPc`, mask AND NOT condition}.
- R8: While the stack is non-empty and `pc` equals the top entry's reconvergence address, `issueValid` is 0. If the entry still has a waiting path, the next edge sets `pc` to its start address and `activeMask` to its saved threads.
- R9: On the second arrival at that address, the next edge pops the entry, keeps `pc`, and restores `activeMask` to the union of both paths' threads.
- R10: Four divergences nest without error and unwind in reverse order, ending with the original mask.
- R11: A divergent branch with four entries already stacked sets `stackErr`, which stays set until launch or reset. That branch still runs its taken threads at `takenPc` and pushes nothing.
- R12: An `advance` in a cycle with `issueValid`=0 is ignored.
- R13: `activeMask` is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| launch | input | 1 | Start a fresh warp |
| launchPc | input | 32 | Start address for launch |
| advance | input | 1 | An instruction at `pc` was issued |
| isBranch | input | 1 | The issued instruction is a conditional branch |
| condVec | input | 32 | Per-thread branch condition |
| takenPc | input | 32 | Branch target |
| fallPc | input | 32 | Fall-through address |
| reconvPc | input | 32 | Address where both paths rejoin |
| pc | output | 32 | Program counter of the warp |
| activeMask | output | 32 | Threads enabled for the instruction at `pc` |
| issueValid | output | 1 | The instruction at `pc` may be issued |
| stackErr | output | 1 | Sticky reconvergence stack overflow |

## Verification
Two functions can fall in the same cycle. A launch can coincide with a divergent branch that would otherwise push a stack entry. An `advance` can also arrive while the unit is busy at a reconvergence point. The bench opens a divergence and then raises `launch` together with a second divergent branch. It checks for the launch address and the full mask, and it checks that a later visit to the old reconvergence address no longer stalls. It also holds `advance` high during a switching cycle and checks that `pc` goes to the waiting path instead of stepping by 4.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;
  typedef struct packed {
    logic launch;
    logic seq;
    logic jumpTaken;
    logic jumpFall;
    logic diverge;
    logic overflow;
    logic switchPath;
    logic pop;
  } divStrobes_t;
endpackage

// File: rtl/simt_div_ctrl.sv
module simt_div_ctrl
  import simt_div_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             launch,
  input  logic             advance,
  input  logic             isBranch,
  input  logic [LANES-1:0] condVec,
  input  logic [LANES-1:0] activeMask,
  input  logic             atReconv,
  input  logic             tosPending,
  input  logic             stackFull,
  output divStrobes_t      strb,
  output logic             issueValid
);
  logic [LANES-1:0] effCond;

  assign effCond    = condVec & activeMask;
  assign issueValid = !atReconv;

  always_comb begin
    strb = '0;
    if (launch) begin
      strb.launch = 1'b1;
    end else if (atReconv) begin
      if (tosPending) strb.switchPath = 1'b1;
      else            strb.pop        = 1'b1;
    end else if (advance) begin
      if (!isBranch)                  strb.seq       = 1'b1;
      else if (effCond == activeMask) strb.jumpTaken = 1'b1;
      else if (effCond == '0)         strb.jumpFall  = 1'b1;
      else if (stackFull)             strb.overflow  = 1'b1;
      else                            strb.diverge   = 1'b1;
    end
  end
endmodule

// File: rtl/simt_div_datapath.sv
module simt_div_datapath
  import simt_div_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PCW   = 32,
  parameter int DEPTH = 4,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobes_t      strb,
  input  logic [PCW-1:0]   launchPc,
  input  logic [LANES-1:0] condVec,
  input  logic [PCW-1:0]   takenPc,
  input  logic [PCW-1:0]   fallPc,
  input  logic [PCW-1:0]   reconvPc,
  output logic [PCW-1:0]   pc,
  output logic [LANES-1:0] activeMask,
  output logic             stackErr,
  output logic             atReconv,
  output logic             tosPending,
  output logic             stackFull
);
  localparam int DW   = $clog2(DEPTH + 1);
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef struct packed {
    logic [PCW-1:0]   rejoin;
    logic [PCW-1:0]   waitPc;
    logic [LANES-1:0] lanes;
    logic             waiting;
  } frame_t;

  frame_t           frames [DEPTH];
  frame_t           tos;
  logic [DW-1:0]    depth;
  logic [DW-1:0]    depthM1;
  logic [IDXW-1:0]  tosIdx;
  logic [IDXW-1:0]  pushIdx;
  logic [LANES-1:0] effCond;

  assign effCond    = condVec & activeMask;
  assign depthM1    = depth - 1'b1;
  assign tosIdx     = depthM1[IDXW-1:0];
  assign pushIdx    = depth[IDXW-1:0];
  assign tos        = frames[tosIdx];
  assign stackFull  = (depth == DW'(DEPTH));
  assign atReconv   = (depth != '0) && (pc == tos.rejoin);
  assign tosPending = tos.waiting;

  for (genvar i = 0; i < DEPTH; i++) begin : g_frame
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        frames[i] <= '0;
      end else if (strb.diverge && pushIdx == IDXW'(i)) begin
        frames[i] <= '{rejoin: reconvPc, waitPc: fallPc,
                       lanes: activeMask & ~condVec, waiting: 1'b1};
      end else if (strb.switchPath && tosIdx == IDXW'(i)) begin
        frames[i].lanes   <= frames[i].lanes | activeMask;
        frames[i].waiting <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc         <= '0;
      activeMask <= '1;
      depth      <= '0;
      stackErr   <= 1'b0;
    end else begin
      unique case (1'b1)
        strb.launch: begin
          pc         <= launchPc;
          activeMask <= '1;
          depth      <= '0;
          stackErr   <= 1'b0;
        end
        strb.seq:       pc <= pc + PCW'(STEP);
        strb.jumpTaken: pc <= takenPc;
        strb.jumpFall:  pc <= fallPc;
        strb.diverge: begin
          pc         <= takenPc;
          activeMask <= effCond;
          depth      <= depth + 1'b1;
        end
        strb.overflow: begin
          pc         <= takenPc;
          activeMask <= effCond;
          stackErr   <= 1'b1;
        end
        strb.switchPath: begin
          pc         <= tos.waitPc;
          activeMask <= tos.lanes;
        end
        strb.pop: begin
          activeMask <= tos.lanes;
          depth      <= depthM1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/simt_diverge_unit.sv
module simt_diverge_unit
  import simt_div_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PCW   = 32,
  parameter int DEPTH = 4,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             launch,
  input  logic [PCW-1:0]   launchPc,
  input  logic             advance,
  input  logic             isBranch,
  input  logic [LANES-1:0] condVec,
  input  logic [PCW-1:0]   takenPc,
  input  logic [PCW-1:0]   fallPc,
  input  logic [PCW-1:0]   reconvPc,
  output logic [PCW-1:0]   pc,
  output logic [LANES-1:0] activeMask,
  output logic             issueValid,
  output logic             stackErr
);
  divStrobes_t strb;
  logic atReconv, tosPending, stackFull;

  simt_div_ctrl #(.LANES(LANES)) u_ctrl (
    .launch(launch), .advance(advance), .isBranch(isBranch),
    .condVec(condVec), .activeMask(activeMask), .atReconv(atReconv),
    .tosPending(tosPending), .stackFull(stackFull),
    .strb(strb), .issueValid(issueValid)
  );

  simt_div_datapath #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH), .STEP(STEP)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .launchPc(launchPc),
    .condVec(condVec), .takenPc(takenPc), .fallPc(fallPc), .reconvPc(reconvPc),
    .pc(pc), .activeMask(activeMask), .stackErr(stackErr),
    .atReconv(atReconv), .tosPending(tosPending), .stackFull(stackFull)
  );
endmodule

// File: rtl/simt_diverge_chk.sv
module simt_diverge_chk #(
  parameter int LANES = 32,
  parameter int PCW   = 32,
  parameter int STEP  = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             launch,
  input logic [PCW-1:0]   launchPc,
  input logic             advance,
  input logic             isBranch,
  input logic [LANES-1:0] condVec,
  input logic [PCW-1:0]   takenPc,
  input logic [PCW-1:0]   pc,
  input logic [LANES-1:0] activeMask,
  input logic             issueValid,
  input logic             stackErr
);
  a_r2_launch: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> (activeMask == '1) && (pc == $past(launchPc)) && !stackErr);

  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rstN)
    (advance && issueValid && !isBranch && !launch)
      |=> (pc == $past(pc) + PCW'(STEP)) && (activeMask == $past(activeMask)));

  a_r4_uniform_taken: assert property (@(posedge clk) disable iff (!rstN)
    (advance && issueValid && isBranch && !launch &&
     ((condVec & activeMask) == activeMask))
      |=> (pc == $past(takenPc)) && (activeMask == $past(activeMask)));

  a_r7_no_new_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (advance && issueValid && isBranch && !launch)
      |=> ((activeMask & ~$past(activeMask)) == '0));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stackErr && !launch) |=> stackErr);

  a_r13_mask_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    activeMask != '0);
endmodule

bind simt_diverge_unit simt_diverge_chk #(.LANES(LANES), .PCW(PCW), .STEP(STEP)) u_chk (
  .clk(clk), .rstN(rstN), .launch(launch), .launchPc(launchPc),
  .advance(advance), .isBranch(isBranch), .condVec(condVec),
  .takenPc(takenPc), .pc(pc), .activeMask(activeMask),
  .issueValid(issueValid), .stackErr(stackErr)
);

// File: tb/simt_diverge_unit_tb.sv
`timescale 1ns/1ps
module simt_diverge_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        launch = 1'b0;
  logic [31:0] launchPc = '0;
  logic        advance = 1'b0;
  logic        isBranch = 1'b0;
  logic [31:0] condVec = '0;
  logic [31:0] takenPc = '0;
  logic [31:0] fallPc = '0;
  logic [31:0] reconvPc = '0;
  logic [31:0] pc;
  logic [31:0] activeMask;
  logic        issueValid;
  logic        stackErr;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  simt_diverge_unit u_dut (
    .clk(clk), .rstN(rstN), .launch(launch), .launchPc(launchPc),
    .advance(advance), .isBranch(isBranch), .condVec(condVec),
    .takenPc(takenPc), .fallPc(fallPc), .reconvPc(reconvPc),
    .pc(pc), .activeMask(activeMask), .issueValid(issueValid), .stackErr(stackErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic doLaunch(input logic [31:0] a);
    launch = 1'b1; launchPc = a;
    @(negedge clk);
    launch = 1'b0;
  endtask

  task automatic seqInsn();
    advance = 1'b1; isBranch = 1'b0;
    @(negedge clk);
    advance = 1'b0;
  endtask

  task automatic branch(input logic [31:0] c, input logic [31:0] t,
                        input logic [31:0] f, input logic [31:0] r);
    advance = 1'b1; isBranch = 1'b1; condVec = c;
    takenPc = t; fallPc = f; reconvPc = r;
    @(negedge clk);
    advance = 1'b0; isBranch = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pc", pc, 32'h0);
    chk("R1 mask", activeMask, 32'hFFFF_FFFF);
    chk("R1 err", {31'b0, stackErr}, 32'h0);
    chk("R1 valid", {31'b0, issueValid}, 32'h1);
  endtask

  task automatic t_uniform();
    doLaunch(32'h100);
    chk("R2 pc", pc, 32'h100);
    chk("R2 mask", activeMask, 32'hFFFF_FFFF);
    seqInsn();
    chk("R3 pc", pc, 32'h104);
    chk("R3 mask", activeMask, 32'hFFFF_FFFF);
    branch(32'hFFFF_FFFF, 32'h180, 32'h108, 32'h1C0);
    chk("R4 pc", pc, 32'h180);
    chk("R4 mask", activeMask, 32'hFFFF_FFFF);
    chk("R4 valid", {31'b0, issueValid}, 32'h1);
    branch(32'h0, 32'h200, 32'h184, 32'h1C0);
    chk("R5 pc", pc, 32'h184);
    chk("R5 mask", activeMask, 32'hFFFF_FFFF);
    chk("R5 valid", {31'b0, issueValid}, 32'h1);
  endtask

  task automatic t_diverge();
    doLaunch(32'h100);
    branch(32'h0000_FFFF, 32'h200, 32'h300, 32'h400);
    chk("R7 pc", pc, 32'h200);
    chk("R7 mask", activeMask, 32'h0000_FFFF);
    // only inactive lanes set: uniform not-taken
    branch(32'hFFFF_0000, 32'h280, 32'h400, 32'h500);
    chk("R6 pc", pc, 32'h400);
    chk("R6 mask", activeMask, 32'h0000_FFFF);
    chk("R8 valid low", {31'b0, issueValid}, 32'h0);
    advance = 1'b1; isBranch = 1'b0;
    @(negedge clk);
    advance = 1'b0;
    chk("R12 pc", pc, 32'h300);
    chk("R8 mask", activeMask, 32'hFFFF_0000);
    chk("R8 valid high", {31'b0, issueValid}, 32'h1);
    branch(32'hFFFF_FFFF, 32'h400, 32'h304, 32'h600);
    chk("R9 valid low", {31'b0, issueValid}, 32'h0);
    idle();
    chk("R9 pc", pc, 32'h400);
    chk("R9 mask", activeMask, 32'hFFFF_FFFF);
    chk("R9 valid", {31'b0, issueValid}, 32'h1);
  endtask

  task automatic t_nest();
    logic [31:0] conds [4] = '{32'h0000_FFFF, 32'h0000_00FF, 32'h0000_000F, 32'h0000_0003};
    logic [31:0] parent [4] = '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_00FF, 32'h0000_000F};
    doLaunch(32'h800);
    for (int k = 0; k < 4; k++) begin
      branch(conds[k], 32'h1000 * (k + 1), 32'h1000 * (k + 1) + 32'h100,
             32'h1000 * (k + 1) + 32'hF00);
      chk("R10 push mask", activeMask, conds[k]);
    end
    chk("R10 err", {31'b0, stackErr}, 32'h0);
    for (int k = 3; k >= 0; k--) begin
      branch(32'h0, 32'h0, 32'h1000 * (k + 1) + 32'hF00, 32'h0);
      idle();
      chk("R10 switch pc", pc, 32'h1000 * (k + 1) + 32'h100);
      chk("R10 switch mask", activeMask, parent[k] & ~conds[k]);
      branch(32'h0, 32'h0, 32'h1000 * (k + 1) + 32'hF00, 32'h0);
      idle();
      chk("R10 pop mask", activeMask, parent[k]);
    end
    chk("R10 final pc", pc, 32'h1F00);
    chk("R10 final valid", {31'b0, issueValid}, 32'h1);
  endtask

  task automatic t_overflow();
    doLaunch(32'h800);
    branch(32'h0000_FFFF, 32'h1000, 32'h1100, 32'h1F00);
    branch(32'h0000_00FF, 32'h2000, 32'h2100, 32'h2F00);
    branch(32'h0000_000F, 32'h3000, 32'h3100, 32'h3F00);
    branch(32'h0000_0003, 32'h4000, 32'h4100, 32'h4F00);
    branch(32'h0000_0001, 32'h5000, 32'h5100, 32'h5F00);
    chk("R11 err", {31'b0, stackErr}, 32'h1);
    chk("R11 pc", pc, 32'h5000);
    chk("R11 mask", activeMask, 32'h0000_0001);
    // no entry for 0x5F00 was pushed: reaching it does not stall
    branch(32'h0, 32'h0, 32'h5F00, 32'h0);
    chk("R11 no push", {31'b0, issueValid}, 32'h1);
    seqInsn();
    chk("R11 sticky", {31'b0, stackErr}, 32'h1);
    doLaunch(32'h900);
    chk("R2 err clear", {31'b0, stackErr}, 32'h0);
  endtask

  task automatic t_collide();
    doLaunch(32'h100);
    branch(32'h0000_00FF, 32'h200, 32'h300, 32'h400);
    launch = 1'b1; launchPc = 32'h500;
    advance = 1'b1; isBranch = 1'b1; condVec = 32'h0000_000F;
    takenPc = 32'h600; fallPc = 32'h700; reconvPc = 32'h800;
    @(negedge clk);
    launch = 1'b0; advance = 1'b0; isBranch = 1'b0;
    chk("R2 collide pc", pc, 32'h500);
    chk("R2 collide mask", activeMask, 32'hFFFF_FFFF);
    branch(32'h0, 32'h0, 32'h400, 32'h0);
    chk("R2 stack empty", {31'b0, issueValid}, 32'h1);
    branch(32'h0, 32'h0, 32'h800, 32'h0);
    chk("R2 stack empty 2", {31'b0, issueValid}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_uniform();
    t_diverge();
    t_nest();
    t_overflow();
    t_collide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule